// File: doc/BRIEF.md
# Serial ADC Read Controller

This block runs conversions on an external 10-bit successive-approximation converter over a three-wire serial link. When a start request arrives, it pulls the active-low chip select low, which makes the converter hold its input and begin converting. It then generates a fixed number of serial clock pulses from the system clock and samples the converter's data line on each rising edge. The data line changes just after every rising edge, so each sample holds the bit that the previous edge produced.

A frame holds three leading zeros, ten result bits sent MSB first, two sub-bits and then trailing bits. At the end of a frame the block returns the result and the sub-bits with a one-cycle valid strobe. It flags the frame when a leading zero reads as one. It also enforces three waits on the chip select: a minimum high time between frames, a longer recovery wait after an aborted frame, and a wake delay after reset or after the shutdown pin is released. It drives the converter's active-low shutdown pin on request. A start request that arrives while the block is busy, waiting or asleep is held and served once the block is free. All timing parameters are counted in system clocks. `WAKE_WAIT`, `CS_GAP` and `CS_GAP + ABORT_WAIT` must each be at least 2, and `WAKE_WAIT` must be no smaller than the other two.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, adcCsN is 1, adcSclk is 0, adcShdnN is 1 and resultValid is 0.
- R2: A frame starts when adcCsN falls. adcSclk stays low for DIV_HALF cycles, then alternates high and low for DIV_HALF cycles each, giving exactly FRAME_CLKS rising edges. adcCsN rises on the edge where the last high phase ends, 2·FRAME_CLKS·DIV_HALF cycles after it fell. adcSclk is 0 whenever adcCsN is 1.
- R3: At the k-th rising edge of adcSclk (counting from 1), the block samples the value adcMiso held just before that edge. Samples 4 to 13 form result, with sample 4 as bit 9 (MSB first). Samples 14 and 15 form subBits, with sample 14 as bit 1. Samples after 15 have no effect.
- R4: resultValid is a one-cycle pulse on the same edge where adcCsN rises at the end of a complete frame. result, subBits and frameErr are valid in that cycle.
- R5: frameErr is 1 with the valid pulse when any of samples 1 to 3 is 1, and 0 otherwise.
- R6: After a complete frame, adcCsN stays high for exactly CS_GAP cycles when a start is waiting.
- R7: When abortReq is 1 during a frame, adcCsN goes high and adcSclk goes low on the next edge, and no valid pulse is produced. adcCsN then stays high for exactly CS_GAP+ABORT_WAIT cycles when a start is waiting. abortReq has no effect outside a frame.
- R8: adcCsN does not fall earlier than the WAKE_WAIT-th edge after reset release, or after the edge that raises adcShdnN. When a start is waiting, it falls exactly on that edge.
- R9: When shdnReq is 1 outside a frame, adcShdnN goes low on the next edge and stays low while shdnReq is 1, and no frame starts. A shdnReq seen during a frame takes effect only after the frame ends. adcShdnN rises on the edge after shdnReq returns to 0.
- R10: A startReq pulse seen while the block is not idle is held and served as soon as the block is idle. Several requests made before a frame launches produce only one frame. A startReq seen while idle makes adcCsN fall on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| startReq | input | 1 | Request one conversion frame |
| abortReq | input | 1 | End the current frame early, without a result |
| shdnReq | input | 1 | Level request to put the converter in shutdown |
| adcMiso | input | 1 | Serial data from the converter |
| adcCsN | output | 1 | Active-low chip select to the converter |
| adcSclk | output | 1 | Serial clock to the converter, idles low |
| adcShdnN | output | 1 | Active-low shutdown pin of the converter |
| result | output | 10 | Conversion result, MSB first on the wire |
| subBits | output | 2 | The two sub-bits that follow the result |
| resultValid | output | 1 | One-cycle strobe marking result, subBits and frameErr |
| frameErr | output | 1 | A leading-zero position read as one |

## Verification
The hardest cases to reach from the ports are start requests that land inside one of the three waits. These are a request pulsed during the wake delay, while asleep, in the middle of a running frame, or in the cycle after an abort. In each case the relaunch edge depends on which wait is active. The stimulus pulses startReq inside each of those windows and combines them with a shutdown request that arrives mid-frame. A behavioural converter model puts three-bit lead patterns and a trailing one into the data stream, so the error flag and the sample positions are checked along with the launch edges.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Control phases of the reader.
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,  // chip select high, counting down a wait
    ST_IDLE   = 2'd1,  // ready to launch
    ST_FRAME  = 2'd2,  // chip select low, clocks running
    ST_SLEEP  = 2'd3   // converter held in shutdown
  } rdState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic clearBits;  // new frame: forget previous samples
    logic sampleEn;   // serial clock rises on this edge: take a sample
    logic publish;    // frame complete: register result and pulse valid
  } dpStrobes_t;

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_HALF   = 10,
  parameter int FRAME_CLKS = 16,
  parameter int CS_GAP     = 13,
  parameter int ABORT_WAIT = 59,
  parameter int WAKE_WAIT  = 175000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       abortReq,
  input  logic       shdnReq,
  output logic       csN,
  output logic       sclk,
  output logic       shdnN,
  output dpStrobes_t strobes
);

  localparam int ABORT_TOTAL = CS_GAP + ABORT_WAIT;
  localparam int SETTLE_MAX  = (WAKE_WAIT > ABORT_TOTAL) ? WAKE_WAIT : ABORT_TOTAL;
  localparam int CNT_W       = $clog2(SETTLE_MAX + 1);
  localparam int HALF_W      = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int EDGE_W      = $clog2(FRAME_CLKS + 1);

  rdState_t            stateQ;
  logic [CNT_W-1:0]    cntQ;
  logic [HALF_W-1:0]   halfQ;
  logic [EDGE_W-1:0]   edgeQ;
  logic                sclkQ;
  logic                csNQ;
  logic                shdnNQ;
  logic                pendQ;

  logic inFrame, halfDone, lastEdge;
  logic abortNow, riseNow, endNow, launchNow;

  always_comb begin
    inFrame   = (stateQ == ST_FRAME);
    halfDone  = (halfQ == HALF_W'(DIV_HALF - 1));
    lastEdge  = (edgeQ == EDGE_W'(FRAME_CLKS));
    abortNow  = inFrame && abortReq;
    riseNow   = inFrame && !abortReq && halfDone && !sclkQ;
    endNow    = inFrame && !abortReq && halfDone && sclkQ && lastEdge;
    launchNow = (stateQ == ST_IDLE) && !shdnReq && (pendQ || startReq);
  end

  always_comb begin
    strobes.clearBits = launchNow;
    strobes.sampleEn  = riseNow;
    strobes.publish   = endNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_SETTLE;
      cntQ   <= CNT_W'(WAKE_WAIT - 1);
      halfQ  <= '0;
      edgeQ  <= '0;
      sclkQ  <= 1'b0;
      csNQ   <= 1'b1;
      shdnNQ <= 1'b1;
      pendQ  <= 1'b0;
    end else begin
      pendQ <= (pendQ | startReq) & ~launchNow;
      case (stateQ)
        ST_SETTLE: begin
          if (shdnReq) begin
            stateQ <= ST_SLEEP;
            shdnNQ <= 1'b0;
          end else begin
            cntQ <= cntQ - CNT_W'(1);
            if (cntQ <= CNT_W'(1)) stateQ <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (shdnReq) begin
            stateQ <= ST_SLEEP;
            shdnNQ <= 1'b0;
          end else if (launchNow) begin
            stateQ <= ST_FRAME;
            csNQ   <= 1'b0;
            sclkQ  <= 1'b0;
            halfQ  <= '0;
            edgeQ  <= '0;
          end
        end
        ST_FRAME: begin
          if (abortNow) begin
            csNQ   <= 1'b1;
            sclkQ  <= 1'b0;
            stateQ <= ST_SETTLE;
            cntQ   <= CNT_W'(ABORT_TOTAL - 1);
          end else if (halfDone) begin
            halfQ <= '0;
            if (!sclkQ) begin
              sclkQ <= 1'b1;
              edgeQ <= edgeQ + EDGE_W'(1);
            end else begin
              sclkQ <= 1'b0;
              if (lastEdge) begin
                csNQ   <= 1'b1;
                stateQ <= ST_SETTLE;
                cntQ   <= CNT_W'(CS_GAP - 1);
              end
            end
          end else begin
            halfQ <= halfQ + HALF_W'(1);
          end
        end
        ST_SLEEP: begin
          if (!shdnReq) begin
            shdnNQ <= 1'b1;
            stateQ <= ST_SETTLE;
            cntQ   <= CNT_W'(WAKE_WAIT - 1);
          end
        end
        default: stateQ <= ST_SETTLE;
      endcase
    end
  end

  assign csN   = csNQ;
  assign sclk  = sclkQ;
  assign shdnN = shdnNQ;

endmodule

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int LEAD_BITS = 3,
  parameter int DATA_BITS = 10,
  parameter int SUB_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobes_t           strobes,
  input  logic                 sdi,
  output logic [DATA_BITS-1:0] result,
  output logic [SUB_BITS-1:0]  subBits,
  output logic                 resultValid,
  output logic                 frameErr
);

  localparam int FIELD = LEAD_BITS + DATA_BITS + SUB_BITS;
  localparam int POS_W = $clog2(FIELD + 1);

  // Sample n (0-based) lands in bit FIELD-1-n: lead on top, sub-bits at the bottom.
  logic [FIELD-1:0] bitsQ;
  logic [POS_W-1:0] posQ;
  logic             posFull;

  assign posFull = (posQ == POS_W'(FIELD));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitsQ <= '0;
      posQ  <= '0;
    end else if (strobes.clearBits) begin
      bitsQ <= '0;
      posQ  <= '0;
    end else if (strobes.sampleEn && !posFull) begin
      posQ <= posQ + POS_W'(1);
      for (int i = 0; i < FIELD; i++) begin
        if (posQ == POS_W'(FIELD - 1 - i)) bitsQ[i] <= sdi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      subBits     <= '0;
      frameErr    <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobes.publish;
      if (strobes.publish) begin
        result   <= bitsQ[SUB_BITS +: DATA_BITS];
        subBits  <= bitsQ[SUB_BITS-1:0];
        frameErr <= |bitsQ[FIELD-1 -: LEAD_BITS];
      end
    end
  end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_HALF   = 10,
  parameter int FRAME_CLKS = 16,
  parameter int CS_GAP     = 13,
  parameter int ABORT_WAIT = 59,
  parameter int WAKE_WAIT  = 175000,
  parameter int LEAD_BITS  = 3,
  parameter int DATA_BITS  = 10,
  parameter int SUB_BITS   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 abortReq,
  input  logic                 shdnReq,
  input  logic                 adcMiso,
  output logic                 adcCsN,
  output logic                 adcSclk,
  output logic                 adcShdnN,
  output logic [DATA_BITS-1:0] result,
  output logic [SUB_BITS-1:0]  subBits,
  output logic                 resultValid,
  output logic                 frameErr
);

  dpStrobes_t dpStb;

  adc_rd_ctrl #(
    .DIV_HALF  (DIV_HALF),
    .FRAME_CLKS(FRAME_CLKS),
    .CS_GAP    (CS_GAP),
    .ABORT_WAIT(ABORT_WAIT),
    .WAKE_WAIT (WAKE_WAIT)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .abortReq(abortReq),
    .shdnReq (shdnReq),
    .csN     (adcCsN),
    .sclk    (adcSclk),
    .shdnN   (adcShdnN),
    .strobes (dpStb)
  );

  adc_rd_datapath #(
    .LEAD_BITS(LEAD_BITS),
    .DATA_BITS(DATA_BITS),
    .SUB_BITS (SUB_BITS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (dpStb),
    .sdi        (adcMiso),
    .result     (result),
    .subBits    (subBits),
    .resultValid(resultValid),
    .frameErr   (frameErr)
  );

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
  parameter int CS_GAP    = 13,
  parameter int WAKE_WAIT = 175000
) (
  input logic clk,
  input logic rstN,
  input logic abortReq,
  input logic shdnReq,
  input logic adcCsN,
  input logic adcSclk,
  input logic adcShdnN,
  input logic resultValid
);

  localparam int LIM   = (WAKE_WAIT > CS_GAP) ? WAKE_WAIT : CS_GAP;
  localparam int CNT_W = $clog2(LIM + 1);

  logic [CNT_W-1:0] highCnt;  // cycles chip select has been high
  logic [CNT_W-1:0] awakeCnt; // cycles since the shutdown pin was released or reset ended

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt  <= '0;
      awakeCnt <= '0;
    end else begin
      if (!adcCsN) highCnt <= '0;
      else if (highCnt != CNT_W'(LIM)) highCnt <= highCnt + CNT_W'(1);
      if (!adcShdnN) awakeCnt <= '0;
      else if (awakeCnt != CNT_W'(LIM)) awakeCnt <= awakeCnt + CNT_W'(1);
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> !adcSclk);

  assert_valid_at_cs_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $rose(adcCsN));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> (highCnt >= CNT_W'(CS_GAP)));

  assert_abort_ends_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!adcCsN && abortReq) |=> (adcCsN && !adcSclk && !resultValid));

  assert_wake_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> (awakeCnt >= CNT_W'(WAKE_WAIT)));

  assert_no_frame_asleep_R9: assert property (@(posedge clk) disable iff (!rstN)
    !adcShdnN |-> adcCsN);

  assert_sleep_on_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcShdnN) |-> $past(shdnReq));

endmodule

bind adc_serial_reader adc_rd_checker #(
  .CS_GAP   (CS_GAP),
  .WAKE_WAIT(WAKE_WAIT)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .abortReq   (abortReq),
  .shdnReq    (shdnReq),
  .adcCsN     (adcCsN),
  .adcSclk    (adcSclk),
  .adcShdnN   (adcShdnN),
  .resultValid(resultValid)
);

// File: tb/adc_serial_reader_tb.sv
`timescale 1ns/1ps
module adc_serial_reader_tb_top;

  localparam int DIV_HALF   = 3;
  localparam int FRAME_CLKS = 16;
  localparam int CS_GAP     = 5;
  localparam int ABORT_WAIT = 7;
  localparam int WAKE_WAIT  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, abortReq = 1'b0, shdnReq = 1'b0, adcMiso = 1'b0;
  logic adcCsN, adcSclk, adcShdnN, resultValid, frameErr;
  logic [9:0] result;
  logic [1:0] subBits;

  always #4 clk = ~clk;  // 125 MHz

  adc_serial_reader #(
    .DIV_HALF(DIV_HALF), .FRAME_CLKS(FRAME_CLKS), .CS_GAP(CS_GAP),
    .ABORT_WAIT(ABORT_WAIT), .WAKE_WAIT(WAKE_WAIT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .shdnReq(shdnReq), .adcMiso(adcMiso), .adcCsN(adcCsN), .adcSclk(adcSclk),
    .adcShdnN(adcShdnN), .result(result), .subBits(subBits),
    .resultValid(resultValid), .frameErr(frameErr)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // ---------------- converter model ----------------
  logic [9:0] devData = '0;
  logic [1:0] devSub  = '0;
  logic [2:0] devLead = '0;
  bit         devTrail = 1'b0;
  bit         stream [0:31];
  int         devIdx = 0;

  always @(negedge adcCsN) begin
    #1;
    for (int k = 0; k < 32; k++) stream[k] = 1'b0;
    stream[0] = devLead[2]; stream[1] = devLead[1]; stream[2] = devLead[0];
    for (int j = 0; j < 10; j++) stream[3+j] = devData[9-j];
    stream[13] = devSub[1]; stream[14] = devSub[0]; stream[15] = devTrail;
    devIdx  = 0;
    adcMiso = stream[0];
  end

  always @(posedge adcSclk) begin
    #1;
    devIdx++;
    adcMiso = (devIdx < 32) ? stream[devIdx] : 1'b0;
  end

  // ---------------- behavioural reference ----------------
  localparam int M_SETTLE = 0, M_IDLE = 1, M_FRAME = 2, M_SLEEP = 3;
  int mMode, mLeft, mT;
  bit mPend;
  bit eCs = 1, eSclk = 0, eShdn = 1, eValid = 0, eErr = 0;
  logic [9:0] eRes = '0;
  logic [1:0] eSub = '0;
  logic [9:0] capData;
  logic [1:0] capSub;
  logic [2:0] capLead;

  task automatic idleAct();
    if (shdnReq) begin
      mMode = M_SLEEP; eShdn = 0;
    end else if (mPend) begin
      eCs = 0; eSclk = 0; mT = 0; mMode = M_FRAME; mPend = 0;
      capData = devData; capSub = devSub; capLead = devLead;
    end else begin
      mMode = M_IDLE;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = M_SETTLE; mLeft = WAKE_WAIT; mPend = 0; mT = 0;
      eCs = 1; eSclk = 0; eShdn = 1; eValid = 0;
    end else begin
      eValid = 0;
      mPend = mPend | startReq;
      case (mMode)
        M_SETTLE: begin
          if (shdnReq) begin
            mMode = M_SLEEP; eShdn = 0;
          end else begin
            mLeft--;
            if (mLeft == 0) idleAct();
          end
        end
        M_IDLE: idleAct();
        M_FRAME: begin
          if (abortReq) begin
            eCs = 1; eSclk = 0; mMode = M_SETTLE; mLeft = CS_GAP + ABORT_WAIT;
          end else begin
            mT++;
            eSclk = ((mT / DIV_HALF) % 2) == 1;
            if (mT == 2 * FRAME_CLKS * DIV_HALF) begin
              eCs = 1; eSclk = 0; eValid = 1;
              eRes = capData; eSub = capSub; eErr = (capLead != 0);
              mMode = M_SETTLE; mLeft = CS_GAP;
            end
          end
        end
        default: begin
          if (!shdnReq) begin
            eShdn = 1; mMode = M_SETTLE; mLeft = WAKE_WAIT;
          end
        end
      endcase
    end
  end

  task automatic cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        // R1: idle levels under reset
        cmp("R1", "adcCsN", adcCsN, 1);
        cmp("R1", "adcSclk", adcSclk, 0);
        cmp("R1", "adcShdnN", adcShdnN, 1);
        cmp("R1", "resultValid", resultValid, 0);
      end else begin
        cmp("R2 R6 R7 R8 R10", "adcCsN", adcCsN, eCs);
        cmp("R2 R7", "adcSclk", adcSclk, eSclk);
        cmp("R9", "adcShdnN", adcShdnN, eShdn);
        cmp("R4 R7", "resultValid", resultValid, eValid);
        if (eValid) begin
          cmp("R3", "result", result, eRes);
          cmp("R3", "subBits", subBits, eSub);
          cmp("R5", "frameErr", frameErr, eErr);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic pulseAbort();
    @(negedge clk) abortReq = 1'b1;
    @(negedge clk) abortReq = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mMode != M_IDLE || mPend) @(negedge clk);
  endtask

  task automatic setWord(logic [9:0] d, logic [1:0] s, logic [2:0] l, bit t);
    devData = d; devSub = s; devLead = l; devTrail = t;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    setWord(10'h3FF, 2'b11, 3'b000, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 R10: request during wake delay is held until the wake count expires
    repeat (3) @(negedge clk);
    pulseStart();
    waitIdle();
    // R3: all-zero word
    setWord(10'h000, 2'b00, 3'b000, 1'b0);
    pulseStart();
    repeat (4) @(negedge clk);
    // R6 R10: two requests during a frame collapse into one, launched after the gap
    setWord(10'h2A5, 2'b01, 3'b000, 1'b1);  // R3: trailing one ignored
    pulseStart();
    pulseStart();
    waitIdle();
    // R5: lead position reads one, per position
    for (int p = 0; p < 3; p++) begin
      setWord(10'h155 + 10'(p), 2'b10, 3'(1 << p), 1'b0);
      pulseStart();
      waitIdle();
    end
    // R7: abort mid-frame, request held through the longer wait
    setWord(10'h0F0, 2'b11, 3'b000, 1'b0);
    pulseStart();
    repeat (10) @(negedge clk);
    pulseAbort();
    setWord(10'h30C, 2'b01, 3'b000, 1'b0);
    pulseStart();
    waitIdle();
    // R7: abort outside a frame has no effect
    repeat (3) @(negedge clk);
    pulseAbort();
    repeat (4) @(negedge clk);
    // R9 R8: shutdown from idle, start held while asleep, wake delay after release
    @(negedge clk) shdnReq = 1'b1;
    repeat (3) @(negedge clk);
    pulseStart();
    repeat (8) @(negedge clk);
    shdnReq = 1'b0;
    waitIdle();
    // R9: shutdown raised mid-frame waits for the frame to finish
    setWord(10'h1C3, 2'b10, 3'b000, 1'b0);
    pulseStart();
    repeat (6) @(negedge clk);
    shdnReq = 1'b1;
    repeat (120) @(negedge clk);
    shdnReq = 1'b0;
    waitIdle();
    // R2 R3: final frame with alternating bits
    setWord(10'h2AA, 2'b01, 3'b000, 1'b0);
    pulseStart();
    waitIdle();
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule